// File: doc/BRIEF.md
# Scaler Initial Phase Calculator

This block works out the starting filter phase for one axis of a polyphase image scaler. The caller presents a 16.16 fixed-point step (source size over destination size), chooses whether the channel is subsampled by two, and says whether its chroma samples are co-sited with luma. One clock later the block returns a 16-bit phase word and a range warning. The same block serves the horizontal and vertical axes and the luma and chroma/RGB channels. It is fed once for each combination, one request per strobe.

The phase is measured from the top-left edge of the first pixel, which lies half a pixel (−0x8000) before the pixel centre where phase 0.0 sits. Half of one output step, divided by the subsampling factor, is added to that start. Co-sited chroma that is subsampled by two also gains a quarter-pixel siting offset. A negative sum is folded up by one whole pixel and reported with the trip bit clear. A sum of zero or more is reported with the trip bit set. The low 15 bits of the word carry the phase with its two lowest fraction bits removed.

Top module: `scl_phase_calc`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, `out_valid`, `phase_word` and `warn_o` are all zero.
- R2: Every cycle with `in_valid` high produces exactly one cycle of `out_valid` high on the next clock edge. A cycle without a strobe is followed by `out_valid` low.
- R3: The signed phase is −0x8000 plus the siting term plus `scale_i / (2*sub)` rounded toward zero. Here sub is 1 when `sub2_i` = 0 and 2 when `sub2_i` = 1, and `scale_i` is unsigned.
- R4: With `sub2_i` = 1 and `cosite_i` = 1 the siting term is +0x4000. In every other case it is zero, so `cosite_i` has no effect on the output when `sub2_i` = 0.
- R5: A negative phase is replaced by 0x10000 plus the phase, and bit 15 (trip) of `phase_word` is 0.
- R6: A phase of zero or more leaves the phase unchanged and sets bit 15 (trip) of `phase_word` to 1.
- R7: Bits [14:0] of `phase_word` equal bits [16:2] of the folded phase. Higher phase bits are dropped.
- R8: `warn_o` is 1 exactly when the phase lies outside −0x8000..0x18000 inclusive. A phase of exactly 0x18000 gives no warning, and any `scale_i` up to 0x30000 never warns.
- R9: In cycles without a strobe, `phase_word` and `warn_o` keep the values from the last strobe, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; the data inputs are sampled in this cycle |
| scale_i | input | 32 | Unsigned 16.16 step, source over destination |
| sub2_i | input | 1 | 0: channel not subsampled, 1: subsampled by two |
| cosite_i | input | 1 | Chroma co-sited with luma |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| phase_word | output | 16 | Bit 15 trip, bits [14:0] phase field |
| warn_o | output | 1 | Phase outside the permitted range |

## Verification
Each result register loads on the clock edge that samples the strobe, so `out_valid`, `phase_word` and `warn_o` are due exactly one cycle after `in_valid`. The bench drives each request on a falling edge and holds it for one cycle. It reads the result on the next falling edge, half a cycle after the loading edge. On the falling edge after that it checks that the strobe has dropped and that the word still holds while the data inputs are changed to unrelated values.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

  typedef enum logic {
    SUBS_NONE = 1'b0,
    SUBS_HALF = 1'b1
  } subs_e;

  typedef struct packed {
    logic trip;
    logic warn;
  } phase_flags_t;

endpackage

// File: rtl/scl_phase_sum.sv
module scl_phase_sum
  import scl_phase_pkg::*;
#(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16,
  localparam int SUM_W  = SCALE_W + 2
) (
  input  logic [SCALE_W-1:0]       scale,
  input  subs_e                    subs,
  input  logic                     cosite,
  output logic signed [SUM_W-1:0]  raw_phase,
  output logic                     raw_neg
);

  localparam logic [SUM_W-1:0] HALF_PIX = SUM_W'(1) << (FRAC_W - 1);

  // Half of one step per subsample: divide by 2*sub, rounding toward zero.
  function automatic logic [SUM_W-1:0] f_step(input logic [SCALE_W-1:0] s,
                                               input subs_e sb);
    logic [SUM_W-1:0] wide;
    wide = SUM_W'(s);
    return (sb == SUBS_HALF) ? (wide >> 2) : (wide >> 1);
  endfunction

  // Siting offset (sub-1)*half/sub: zero unless subsampled and co-sited.
  function automatic logic [SUM_W-1:0] f_siting(input subs_e sb, input logic cs);
    return (sb == SUBS_HALF && cs) ? (HALF_PIX >> 1) : '0;
  endfunction

  logic [SUM_W-1:0] step_term;
  logic [SUM_W-1:0] site_term;

  always_comb begin
    step_term = f_step(scale, subs);
    site_term = f_siting(subs, cosite);
    raw_phase = $signed(step_term + site_term - HALF_PIX);
    raw_neg   = raw_phase[SUM_W-1];
  end

endmodule

// File: rtl/scl_phase_encode.sv
module scl_phase_encode
  import scl_phase_pkg::*;
#(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16,
  parameter int FIELD_W = 15,
  localparam int SUM_W  = SCALE_W + 2,
  localparam int SHIFT  = FRAC_W + 1 - FIELD_W
) (
  input  logic signed [SUM_W-1:0] raw_phase,
  output logic [FIELD_W-1:0]      field,
  output phase_flags_t            flags
);

  localparam logic signed [SUM_W-1:0] ONE_PIX = SUM_W'(1) << FRAC_W;
  localparam logic signed [SUM_W-1:0] LO_LIM  = -(ONE_PIX >>> 1);
  localparam logic signed [SUM_W-1:0] HI_LIM  = ONE_PIX + (ONE_PIX >>> 1);

  function automatic logic signed [SUM_W-1:0] f_fold(input logic signed [SUM_W-1:0] p);
    return (p < 0) ? (p + ONE_PIX) : p;
  endfunction

  logic signed [SUM_W-1:0] folded;
  logic [SUM_W-1:0]        shifted;

  always_comb begin
    folded     = f_fold(raw_phase);
    shifted    = folded >> SHIFT;
    field      = FIELD_W'(shifted);
    flags.trip = (raw_phase >= 0);
    flags.warn = (raw_phase < LO_LIM) || (raw_phase > HI_LIM);
  end

endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_phase_pkg::*;
#(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16,
  parameter int FIELD_W = 15,
  localparam int WORD_W = FIELD_W + 1,
  localparam int SUM_W  = SCALE_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               sub2_i,
  input  logic               cosite_i,
  output logic               out_valid,
  output logic [WORD_W-1:0]  phase_word,
  output logic               warn_o
);

  logic signed [SUM_W-1:0] raw_phase;
  logic                    raw_neg;
  logic [FIELD_W-1:0]      field;
  phase_flags_t            flags;
  subs_e                   subs;

  assign subs = subs_e'(sub2_i);

  scl_phase_sum #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u_sum (
    .scale     (scale_i),
    .subs      (subs),
    .cosite    (cosite_i),
    .raw_phase (raw_phase),
    .raw_neg   (raw_neg)
  );

  scl_phase_encode #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .FIELD_W(FIELD_W)) u_enc (
    .raw_phase (raw_phase),
    .field     (field),
    .flags     (flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      phase_word <= '0;
      warn_o     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        phase_word <= {flags.trip, field};
        warn_o     <= flags.warn;
      end
    end
  end

endmodule

// File: rtl/scl_phase_chk.sv
module scl_phase_chk #(
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 16,
  parameter int WORD_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [SCALE_W-1:0] scale_i,
  input logic               out_valid,
  input logic [WORD_W-1:0]  phase_word,
  input logic               warn_o,
  input logic               raw_neg
);

  localparam logic [SCALE_W-1:0] MAX_SCALE = SCALE_W'(3) << FRAC_W;

  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_trip_clear_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && raw_neg) |=> !phase_word[WORD_W-1]);

  p_trip_set_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !raw_neg) |=> phase_word[WORD_W-1]);

  p_no_warn_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scale_i <= MAX_SCALE) |=> !warn_o);

  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phase_word) && $stable(warn_o)));

endmodule

bind scl_phase_calc scl_phase_chk #(
  .SCALE_W (SCALE_W),
  .FRAC_W  (FRAC_W),
  .WORD_W  (WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .scale_i    (scale_i),
  .out_valid  (out_valid),
  .phase_word (phase_word),
  .warn_o     (warn_o),
  .raw_neg    (raw_neg)
);

// File: tb/scl_phase_calc_tb.sv
module scl_phase_calc_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 14;

  // Entry: {scale[31:0], sub2, cosite, expected word[15:0], expected warn}
  localparam logic [50:0] VEC [NVEC] = '{
    {32'h0001_0000, 1'b0, 1'b0, 16'h8000, 1'b0},  // R3 R6 unity step -> phase 0
    {32'h0004_0000, 1'b0, 1'b0, 16'hE000, 1'b0},  // R8 exactly 0x18000, no warn
    {32'h0000_4000, 1'b0, 1'b0, 16'h2800, 1'b0},  // R5 upscale 1:4
    {32'h0004_0002, 1'b0, 1'b0, 16'hE000, 1'b1},  // R8 0x18001 warns
    {32'h0001_0000, 1'b1, 1'b1, 16'h8000, 1'b0},  // R4 co-sited sub 2
    {32'h0001_0000, 1'b1, 1'b0, 16'h3000, 1'b0},  // R4 sub 2 without siting
    {32'h0003_0000, 1'b0, 1'b0, 16'hC000, 1'b0},  // R8 max scale 3.0
    {32'h0002_0000, 1'b1, 1'b1, 16'h9000, 1'b0},  // R3 R4 sum
    {32'h0000_0000, 1'b0, 1'b0, 16'h2000, 1'b0},  // R5 lowest phase
    {32'h0000_0003, 1'b0, 1'b0, 16'h2000, 1'b0},  // R3 truncating divide
    {32'h0000_0007, 1'b1, 1'b0, 16'h2000, 1'b0},  // R3 truncating divide by 4
    {32'h0001_FFFF, 1'b0, 1'b0, 16'h9FFF, 1'b0},  // R7 field bits
    {32'hFFFF_FFFF, 1'b0, 1'b0, 16'hDFFF, 1'b1},  // R7 R8 high bits dropped
    {32'h0001_0000, 1'b0, 1'b1, 16'h8000, 1'b0}   // R4 cosite ignored at sub 1
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] scale_i;
  logic        sub2_i;
  logic        cosite_i;
  logic        out_valid;
  logic [15:0] phase_word;
  logic        warn_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scl_phase_calc u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .scale_i    (scale_i),
    .sub2_i     (sub2_i),
    .cosite_i   (cosite_i),
    .out_valid  (out_valid),
    .phase_word (phase_word),
    .warn_o     (warn_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bench-side model written with plain integer arithmetic.
  function automatic logic [16:0] model(input logic [31:0] sc, input logic s2, input logic cs);
    longint ph;
    longint wrapped;
    logic   trip;
    logic   wrn;
    int     sub;
    sub = s2 ? 2 : 1;
    ph  = -32768 + ((s2 && cs) ? 16384 : 0) + longint'(sc) / (2 * sub);
    wrn = (ph < -32768) || (ph > 98304);
    trip = (ph >= 0);
    wrapped = (ph < 0) ? ph + 65536 : ph;
    return {trip, 15'((wrapped / 4) % 32768), wrn};
  endfunction

  task automatic apply(input logic [31:0] sc, input logic s2, input logic cs,
                       input logic [15:0] ew, input logic ewarn, input string tag);
    @(negedge clk);
    scale_i  = sc;
    sub2_i   = s2;
    cosite_i = cs;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    scale_i  = ~sc;
    sub2_i   = ~s2;
    cosite_i = ~cs;
    chk({tag, " R2 valid"}, 32'(out_valid), 32'd1);
    chk({tag, " R3/R5/R6/R7 word"}, 32'(phase_word), 32'(ew));
    chk({tag, " R8 warn"}, 32'(warn_o), 32'(ewarn));
    @(negedge clk);
    chk({tag, " R2 single pulse"}, 32'(out_valid), 32'd0);
    chk({tag, " R9 word held"}, 32'(phase_word), 32'(ew));
    chk({tag, " R9 warn held"}, 32'(warn_o), 32'(ewarn));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    scale_i  = 32'h0003_0000;
    sub2_i   = 1'b0;
    cosite_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 word in reset", 32'(phase_word), 32'd0);
    chk("R1 warn in reset", 32'(warn_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 32'd0);
    chk("R1 word after reset", 32'(phase_word), 32'd0);

    foreach (VEC[i]) begin
      apply(VEC[i][50:19], VEC[i][18], VEC[i][17], VEC[i][16:1], VEC[i][0], $sformatf("vec%0d", i));
    end

    // Sweep against the bench model over both sub settings and both siting flags.
    for (int k = 0; k < 40; k++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] sc;
        logic [16:0] exp_v;
        sc = 32'(k) * 32'h0000_2A31 + 32'(m);
        exp_v = model(sc, m[1], m[0]);
        apply(sc, m[1], m[0], exp_v[16:1], exp_v[0], $sformatf("sweep%0d_%0d R3 R4", k, m));
      end
    end

    // Back-to-back strobes: R2 one result per strobe.
    @(negedge clk);
    in_valid = 1'b1; scale_i = 32'h0000_4000; sub2_i = 1'b0; cosite_i = 1'b0;
    @(negedge clk);
    chk("R2 back-to-back first", 32'(phase_word), 32'h2800);
    scale_i = 32'h0004_0000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 back-to-back valid", 32'(out_valid), 32'd1);
    chk("R6 back-to-back second", 32'(phase_word), 32'hE000);

    // Reset mid-run clears results (R1).
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset word", 32'(phase_word), 32'd0);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule